// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block decides whether the protected output rail is fed from the main supply or from a backup battery. It works purely on digital flags produced by external comparators: supply above the reset threshold, supply above the battery voltage, supply below its minimum working level, and battery above its health threshold. It drives the enables of the two rail switches and a status line that reports battery operation. A manual input can force battery operation at any time.

Besides source selection, the block runs a periodic battery health test. It pulses a load-enable output for a short window once per period and samples the battery-health comparator at the end of that window. It also implements a shipping seal. When a factory power-up sequence of the right length is seen, the battery is kept isolated until the system next comes out of reset with the supply present. All timing is counted in ticks of an external timebase strobe `tick_i`, so the same RTL serves any clock rate.

Top module: `bbsw_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sel_main_o`=1, `sel_bat_o`=0, `on_bat_o`=0, `load_en_o`=0, `bat_ok_o`=1 and `sealed_o`=0.
- R2: Outside manual and minimum-level forcing, the battery is the wanted source only when both `vdd_ok_i`=0 and `vdd_gt_bat_i`=0. A supply below threshold but above the battery, or above threshold but below the battery, keeps the main supply.
- R3: From battery operation, the rail returns to the main supply as soon as either `vdd_ok_i` or `vdd_gt_bat_i` goes high.
- R4: `vdd_low_i`=1 makes the battery the wanted source whatever the other comparator flags are.
- R5: `force_bat_i`=1 makes the battery the wanted source even with a healthy supply. With `force_bat_i`=0 the automatic rules decide.
- R6: Every source change is break-before-make. The clock edge after the wanted source changes turns both selects off, and the following edge turns on the new source. The two selects are never high together.
- R7: `on_bat_o` equals `sel_bat_o` in every cycle.
- R8: While `sys_rst_i` is high there are no load pulses. After it falls, `load_en_o` goes high on the next edge for LOAD_TICKS ticks, and the pulse repeats every PERIOD_TICKS ticks.
- R9: On the tick that ends a load pulse, `bat_ok_cmp_i`=0 clears `bat_ok_o`, which then stays low until `rst_ni`. A low comparator outside a pulse, or a high one at a pulse end, leaves `bat_ok_o` unchanged.
- R10: `sealed_o` is set on the edge at which `vdd_ok_i` falls, but only if the preceding run of ticks satisfied all of the following throughout: `vdd_ok_i`, `sys_rst_i`, `bat_present_i`, `pfo_low_i` and `pfi_at_vdd_i` were all high. That run must also have lasted between SEAL_MIN_TICKS and SEAL_MAX_TICKS ticks inclusive. Shorter or longer runs leave it clear.
- R11: While sealed, the battery is never selected and no load pulses occur, even if `sys_rst_i` is low.
- R12: The seal is cleared on the edge at which `sys_rst_i` falls while `vdd_ok_i` is high, and the battery test restarts on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| vdd_ok_i | input | 1 | Supply above reset threshold |
| vdd_gt_bat_i | input | 1 | Supply above battery voltage |
| vdd_low_i | input | 1 | Supply below minimum working level |
| bat_ok_cmp_i | input | 1 | Battery above health threshold (valid under load) |
| force_bat_i | input | 1 | Manual request for battery operation |
| sys_rst_i | input | 1 | System reset state, high while reset is asserted |
| bat_present_i | input | 1 | Battery detected at its input |
| pfo_low_i | input | 1 | Power-fail output held low from outside |
| pfi_at_vdd_i | input | 1 | Power-fail input tied to the supply |
| sel_main_o | output | 1 | Main supply switch enable |
| sel_bat_o | output | 1 | Battery switch enable |
| on_bat_o | output | 1 | Status: rail fed from battery |
| load_en_o | output | 1 | Battery test load enable |
| bat_ok_o | output | 1 | Battery health flag |
| sealed_o | output | 1 | Shipping seal active |

## Verification
A wrong source state shows up at the switch enables within two cycles of a comparator change. It appears either as a missing dead cycle, as both enables high, or as the wrong final enable. An error in the test phase counter shows as a load pulse of the wrong length or position within one period. A wrongly timed sample shows as `bat_ok_o` falling on a tick outside the pulse or failing to fall. A wrong seal state is visible as soon as the supply drops: either the battery is connected while it should stay isolated, or load pulses run while sealed.

// File: rtl/bbsw_pkg.sv
package bbsw_pkg;
  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_GAP  = 2'd1,
    SRC_BAT  = 2'd2
  } src_e;
endpackage

// File: rtl/bbsw_src_fsm.sv
module bbsw_src_fsm
  import bbsw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_bat_i,
  output logic sel_main_o,
  output logic sel_bat_o
);
  src_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_MAIN: if (want_bat_i)  state_d = SRC_GAP;
      SRC_GAP:  state_d = want_bat_i ? SRC_BAT : SRC_MAIN;
      SRC_BAT:  if (!want_bat_i) state_d = SRC_GAP;
      default:  state_d = SRC_GAP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SRC_MAIN;
    else         state_q <= state_d;
  end

  assign sel_main_o = (state_q == SRC_MAIN);
  assign sel_bat_o  = (state_q == SRC_BAT);
endmodule

// File: rtl/bbsw_bat_check.sv
module bbsw_bat_check #(
  parameter int unsigned PERIOD_TICKS = 200000,
  parameter int unsigned LOAD_TICKS   = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sys_rst_i,
  input  logic sealed_i,
  input  logic bat_ok_cmp_i,
  output logic load_en_o,
  output logic bat_ok_o
);
  localparam int unsigned PW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [PW-1:0] LAST    = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] LOAD_N  = PW'(LOAD_TICKS);
  localparam logic [PW-1:0] LOAD_LST = PW'(LOAD_TICKS - 1);

  logic [PW-1:0] phase_q;
  logic          run_q;
  logic          ok_q;
  logic          active;
  logic          pulse_end;

  assign active    = run_q && !sealed_i;
  assign pulse_end = active && tick_i && (phase_q == LOAD_LST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      ok_q    <= 1'b1;
    end else begin
      run_q <= !sys_rst_i && !sealed_i;
      if (!active)     phase_q <= '0;
      else if (tick_i) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (pulse_end && !bat_ok_cmp_i) ok_q <= 1'b0;
    end
  end

  assign load_en_o = active && (phase_q < LOAD_N);
  assign bat_ok_o  = ok_q;
endmodule

// File: rtl/bbsw_seal.sv
module bbsw_seal #(
  parameter int unsigned SEAL_MIN_TICKS = 5000,
  parameter int unsigned SEAL_MAX_TICKS = 35000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vdd_ok_i,
  input  logic sys_rst_i,
  input  logic bat_present_i,
  input  logic pfo_low_i,
  input  logic pfi_at_vdd_i,
  output logic sealed_o
);
  localparam int unsigned CW = $clog2(SEAL_MAX_TICKS + 2);
  localparam logic [CW-1:0] SAT  = CW'(SEAL_MAX_TICKS + 1);
  localparam logic [CW-1:0] LO_T = CW'(SEAL_MIN_TICKS);
  localparam logic [CW-1:0] HI_T = CW'(SEAL_MAX_TICKS);

  logic [CW-1:0] cnt_q;
  logic          vdd_prev_q, rst_prev_q, sealed_q;
  logic          armed, vdd_fall, rst_rel;

  assign armed    = vdd_ok_i && sys_rst_i && bat_present_i && pfo_low_i && pfi_at_vdd_i;
  assign vdd_fall = vdd_prev_q && !vdd_ok_i;
  assign rst_rel  = rst_prev_q && !sys_rst_i && vdd_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      vdd_prev_q <= 1'b0;
      rst_prev_q <= 1'b1;
      sealed_q   <= 1'b0;
    end else begin
      vdd_prev_q <= vdd_ok_i;
      rst_prev_q <= sys_rst_i;
      if (vdd_fall) begin
        if (cnt_q >= LO_T && cnt_q <= HI_T) sealed_q <= 1'b1;
        cnt_q <= '0;
      end else if (!armed) begin
        cnt_q <= '0;
      end else if (tick_i && cnt_q != SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (sealed_q && rst_rel) sealed_q <= 1'b0;
    end
  end

  assign sealed_o = sealed_q;
endmodule

// File: rtl/bbsw_ctrl.sv
module bbsw_ctrl #(
  parameter int unsigned PERIOD_TICKS   = 200000,
  parameter int unsigned LOAD_TICKS     = 25,
  parameter int unsigned SEAL_MIN_TICKS = 5000,
  parameter int unsigned SEAL_MAX_TICKS = 35000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vdd_ok_i,
  input  logic vdd_gt_bat_i,
  input  logic vdd_low_i,
  input  logic bat_ok_cmp_i,
  input  logic force_bat_i,
  input  logic sys_rst_i,
  input  logic bat_present_i,
  input  logic pfo_low_i,
  input  logic pfi_at_vdd_i,
  output logic sel_main_o,
  output logic sel_bat_o,
  output logic on_bat_o,
  output logic load_en_o,
  output logic bat_ok_o,
  output logic sealed_o
);
  logic sealed;
  logic want_bat;
  logic sel_bat;

  // battery only when supply is under both references, or forced
  assign want_bat = !sealed &&
                    (force_bat_i || vdd_low_i || (!vdd_ok_i && !vdd_gt_bat_i));

  bbsw_seal #(
    .SEAL_MIN_TICKS(SEAL_MIN_TICKS),
    .SEAL_MAX_TICKS(SEAL_MAX_TICKS)
  ) i_seal (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick_i),
    .vdd_ok_i      (vdd_ok_i),
    .sys_rst_i     (sys_rst_i),
    .bat_present_i (bat_present_i),
    .pfo_low_i     (pfo_low_i),
    .pfi_at_vdd_i  (pfi_at_vdd_i),
    .sealed_o      (sealed)
  );

  bbsw_src_fsm i_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .want_bat_i (want_bat),
    .sel_main_o (sel_main_o),
    .sel_bat_o  (sel_bat)
  );

  bbsw_bat_check #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .LOAD_TICKS  (LOAD_TICKS)
  ) i_chk_bat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .sys_rst_i    (sys_rst_i),
    .sealed_i     (sealed),
    .bat_ok_cmp_i (bat_ok_cmp_i),
    .load_en_o    (load_en_o),
    .bat_ok_o     (bat_ok_o)
  );

  assign sel_bat_o = sel_bat;
  assign on_bat_o  = sel_bat;
  assign sealed_o  = sealed;
endmodule

// File: rtl/bbsw_ctrl_chk.sv
module bbsw_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_rst_i,
  input logic sel_main_o,
  input logic sel_bat_o,
  input logic on_bat_o,
  input logic load_en_o,
  input logic bat_ok_o,
  input logic sealed_o
);
  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_main_o && sel_bat_o));
  // R6
  bat_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_bat_o) |-> !$past(sel_main_o));
  // R6
  main_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_main_o) |-> !$past(sel_bat_o));
  // R7
  mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_bat_o == sel_bat_o);
  // R8
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_en_o) |-> !$past(sys_rst_i));
  // R9
  ok_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(bat_ok_o));
  // R9
  ok_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bat_ok_o) |-> $past(load_en_o));
  // R11
  seal_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sealed_o && $past(sealed_o)) |-> (!sel_bat_o && !load_en_o));
endmodule

bind bbsw_ctrl bbsw_ctrl_chk i_bbsw_ctrl_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_i  (sys_rst_i),
  .sel_main_o (sel_main_o),
  .sel_bat_o  (sel_bat_o),
  .on_bat_o   (on_bat_o),
  .load_en_o  (load_en_o),
  .bat_ok_o   (bat_ok_o),
  .sealed_o   (sealed_o)
);

// File: tb/test_bbsw_ctrl.sv
module test_bbsw_ctrl;
  localparam int unsigned PER = 20;
  localparam int unsigned LD  = 3;
  localparam int unsigned SMIN = 5;
  localparam int unsigned SMAX = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic vdd_ok_i = 1'b1, vdd_gt_bat_i = 1'b1, vdd_low_i = 1'b0;
  logic bat_ok_cmp_i = 1'b1, force_bat_i = 1'b0, sys_rst_i = 1'b1;
  logic bat_present_i = 1'b0, pfo_low_i = 1'b0, pfi_at_vdd_i = 1'b0;
  logic sel_main_o, sel_bat_o, on_bat_o, load_en_o, bat_ok_o, sealed_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bbsw_ctrl #(
    .PERIOD_TICKS(PER), .LOAD_TICKS(LD),
    .SEAL_MIN_TICKS(SMIN), .SEAL_MAX_TICKS(SMAX)
  ) i_bbsw_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .vdd_ok_i(vdd_ok_i), .vdd_gt_bat_i(vdd_gt_bat_i), .vdd_low_i(vdd_low_i),
    .bat_ok_cmp_i(bat_ok_cmp_i), .force_bat_i(force_bat_i), .sys_rst_i(sys_rst_i),
    .bat_present_i(bat_present_i), .pfo_low_i(pfo_low_i), .pfi_at_vdd_i(pfi_at_vdd_i),
    .sel_main_o(sel_main_o), .sel_bat_o(sel_bat_o), .on_bat_o(on_bat_o),
    .load_en_o(load_en_o), .bat_ok_o(bat_ok_o), .sealed_o(sealed_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // expects a settled source: 1 = battery, 0 = main
  task automatic chk_src(input string tag, input logic bat);
    chk({tag, " sel_main"}, sel_main_o, !bat);
    chk({tag, " sel_bat"}, sel_bat_o, bat);
    chk({tag, " on_bat R7"}, on_bat_o, bat);
  endtask

  task automatic chk_gap(input string tag);
    chk({tag, " gap main R6"}, sel_main_o, 1'b0);
    chk({tag, " gap bat R6"}, sel_bat_o, 1'b0);
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 sel_main", sel_main_o, 1'b1);
    chk("R1 sel_bat", sel_bat_o, 1'b0);
    chk("R1 on_bat", on_bat_o, 1'b0);
    chk("R1 load_en", load_en_o, 1'b0);
    chk("R1 bat_ok", bat_ok_o, 1'b1);
    chk("R1 sealed", sealed_o, 1'b0);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_auto;
    vdd_ok_i = 1'b0; vdd_gt_bat_i = 1'b1;
    step(3); chk_src("R2 below thr above bat", 1'b0);
    vdd_ok_i = 1'b1; vdd_gt_bat_i = 1'b0;
    step(3); chk_src("R2 above thr below bat", 1'b0);
    vdd_ok_i = 1'b0;
    step(1); chk_gap("R2 to bat");
    step(1); chk_src("R2 on battery", 1'b1);
    vdd_gt_bat_i = 1'b1;
    step(1); chk_gap("R3 cross bat");
    step(1); chk_src("R3 back via bat cross", 1'b0);
    vdd_gt_bat_i = 1'b0;
    step(2); chk_src("R2 again battery", 1'b1);
    vdd_ok_i = 1'b1;
    step(1); chk_gap("R3 thr");
    step(1); chk_src("R3 back via thr", 1'b0);
    vdd_gt_bat_i = 1'b1;
  endtask

  task automatic t_min;
    vdd_ok_i = 1'b0; vdd_gt_bat_i = 1'b1; vdd_low_i = 1'b1;
    step(1); chk_gap("R4 min");
    step(1); chk_src("R4 below min", 1'b1);
    vdd_low_i = 1'b0;
    step(2); chk_src("R4 min cleared", 1'b0);
    vdd_ok_i = 1'b1;
  endtask

  task automatic t_manual;
    force_bat_i = 1'b1;
    step(1); chk_gap("R5 force");
    step(1); chk_src("R5 forced battery", 1'b1);
    step(4); chk_src("R5 held", 1'b1);
    force_bat_i = 1'b0;
    step(1); chk_gap("R5 release");
    step(1); chk_src("R5 auto main", 1'b0);
  endtask

  task automatic t_check;
    int highs;
    bit stray;
    stray = 1'b0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (load_en_o) stray = 1'b1;
    end
    chk("R8 no pulse in reset", stray, 1'b0);
    sys_rst_i = 1'b0;
    highs = 0;
    for (int k = 0; k < 24; k++) begin
      step(1);
      if (k == 0)  chk("R8 pulse starts", load_en_o, 1'b1);
      if (k == LD) chk("R8 pulse ends", load_en_o, 1'b0);
      if (k < PER && load_en_o) highs++;
      if (k == 10) bat_ok_cmp_i = 1'b0;
      if (k == 19) chk("R9 low outside pulse ignored", bat_ok_o, 1'b1);
      if (k == PER) chk("R8 next pulse", load_en_o, 1'b1);
      if (k == PER + LD - 1) chk("R9 not yet sampled", bat_ok_o, 1'b1);
      if (k == PER + LD) chk("R9 cleared at pulse end", bat_ok_o, 1'b0);
    end
    chk("R8 pulse length", highs == LD, 1'b1);
    bat_ok_cmp_i = 1'b1;
    step(2 * PER);
    chk("R9 sticky low", bat_ok_o, 1'b0);
    sys_rst_i = 1'b1;
    step(2);
  endtask

  task automatic run_seal(input int n);
    vdd_ok_i = 1'b1;
    step(n);
    vdd_ok_i = 1'b0;
    step(2);
  endtask

  task automatic t_seal;
    bit stray;
    bat_present_i = 1'b1; pfo_low_i = 1'b1; pfi_at_vdd_i = 1'b1;
    run_seal(3);
    chk("R10 too short", sealed_o, 1'b0);
    run_seal(20);
    chk("R10 too long", sealed_o, 1'b0);
    vdd_gt_bat_i = 1'b0;
    step(2);
    chk_src("R10 setup on battery", 1'b1);
    vdd_gt_bat_i = 1'b1;
    step(2);
    run_seal(8);
    chk("R10 in window", sealed_o, 1'b1);
    vdd_gt_bat_i = 1'b0;
    sys_rst_i = 1'b0;
    stray = 1'b0;
    for (int i = 0; i < 30; i++) begin
      step(1);
      if (sel_bat_o || load_en_o || !sel_main_o) stray = 1'b1;
    end
    chk("R11 isolated", stray, 1'b0);
    chk("R11 still sealed", sealed_o, 1'b1);
    sys_rst_i = 1'b1; vdd_ok_i = 1'b1; vdd_gt_bat_i = 1'b1;
    bat_present_i = 1'b0;
    step(3);
    chk("R12 not cleared by supply alone", sealed_o, 1'b1);
    sys_rst_i = 1'b0;
    step(1);
    chk("R12 cleared on reset release", sealed_o, 1'b0);
    step(1);
    chk("R12 test restarts", load_en_o, 1'b1);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    t_reset;
    t_auto;
    t_min;
    t_manual;
    t_check;
    t_seal;
    if (!done) begin
      done = 1'b1;
      summary;
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary;
      $finish;
    end
  end
endmodule